// File: doc/BRIEF.md
# Direct-Mapped Level-1 Instruction Cache with Multi-Beat Refill

This block sits between a processor fetch unit and a slower instruction memory. The fetch unit presents a word address together with an enable. On a hit the block returns the instruction word one cycle later. On a miss it raises a busy flag and loads the whole cache line from memory. It then returns the word in the cycle the flag drops. Only one miss is ever outstanding, and fetch inputs presented while busy is high are ignored.

The memory port may be narrower than a cache line. A refill is therefore split into several reads on consecutive cycles. A local beat counter supplies the low memory-address bits, and the line-aligned part of the missing fetch address supplies the rest. The memory answers each read on the cycle after it sees its enable. An invalidate input drops every line at once, for use when a new program is loaded. If it arrives during a refill, the refill in flight is discarded and started again from the first beat.

Top module: `icache_l1`

## Requirements
- R1: After reset `fetch_busy` and `mem_en` are low, every line is invalid, and the first fetch to any address misses.
- R2: A request is accepted at a clock edge where `fetch_en` is high and `fetch_busy` is low. On a hit, `fetch_busy` stays low, no memory read is issued, and the addressed word is on `fetch_data` in the following cycle.
- R3: Bits [OFF_W-1:0] of the fetch address (OFF_W = log2 BLOCK_WORDS) pick word w of a line, which is line bits [w*WORD_W +: WORD_W]. The next log2 LINES bits pick the line, and the remaining upper bits form the tag.
- R4: A line whose valid bit is clear misses even when its stored tag equals the address tag. A line holding a different tag also misses.
- R5: A refill issues BEATS = BLOCK_WORDS*WORD_W/MEM_W reads on consecutive cycles. Read b has `mem_addr` = {fetch_addr[ADDR_W-1:OFF_W], b} with b ascending from 0. The data arrives on `mem_rdata` one cycle after the read, and beat b fills line bits [b*MEM_W +: MEM_W].
- R6: On a miss, `fetch_busy` is high for exactly BEATS+1 cycles, starting in the cycle after the accepting edge. The requested word is on `fetch_data` in the first cycle with busy low.
- R7: `mem_en` is high only during refill beats, and never while `fetch_busy` is low.
- R8: A pulse on `invalidate` clears every valid bit. A request accepted at the same edge as the pulse is treated as a miss.
- R9: An `invalidate` during a refill clears all lines and abandons the refill. Responses to reads already issued are discarded, and a fresh refill of all BEATS reads starts from beat 0 at that edge. The stalled fetch then completes with the correct word.
- R10: While `fetch_busy` is high, changes on `fetch_en` and `fetch_addr` have no effect on the refill addresses or on the word returned.
- R11: After a refill completes, a fetch of any word of the same line hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_en | input | 1 | Fetch request strobe |
| fetch_addr | input | ADDR_W | Instruction word address |
| fetch_data | output | WORD_W | Returned instruction word |
| fetch_busy | output | 1 | Stall: request not yet answered |
| invalidate | input | 1 | Clear all valid bits |
| mem_en | output | 1 | Memory read strobe, one per beat |
| mem_addr | output | ADDR_W-OFF_W+BEAT_W | Memory beat address |
| mem_rdata | input | MEM_W | Memory read data, one cycle after `mem_en` |

## Verification
A corrupted valid or tag bit shows at the ports within the cycle after the next request to that line. A spurious hit keeps busy low but returns the wrong word, and a spurious miss raises busy and issues memory reads. A beat counter that slips shows at once on `mem_addr` during a refill. A slip on the capture side, or a stale response taken after an abandoned refill, appears as a wrong `fetch_data` in the cycle busy drops. A second fetch of the same line then shows that the wrong content was stored.

// File: rtl/icache_pkg.sv
package icache_pkg;

  typedef enum logic [0:0] {
    FILL_IDLE = 1'b0,
    FILL_RUN  = 1'b1
  } fill_state_t;

endpackage

// File: rtl/icache_tag_store.sv
module icache_tag_store #(
  parameter int LINES = 8,
  parameter int TAG_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clear,
  input  logic [$clog2(LINES)-1:0] rd_idx,
  input  logic [TAG_W-1:0]         rd_tag,
  output logic                     rd_hit,
  input  logic                     wr_en,
  input  logic [$clog2(LINES)-1:0] wr_idx,
  input  logic [TAG_W-1:0]         wr_tag
);
  localparam int IDX_W = $clog2(LINES);

  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_mem [LINES];

  // Valid bits live in flops so that one edge can clear them all.
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      valid_q <= '0;
    end else begin
      for (int l = 0; l < LINES; l++) begin
        if (wr_en && wr_idx == IDX_W'(l)) valid_q[l] <= 1'b1;
      end
    end
  end

  // Tags go to a plain RAM array: no reset, one write port.
  always_ff @(posedge clk) begin
    if (wr_en) tag_mem[wr_idx] <= wr_tag;
  end

  assign rd_hit = valid_q[rd_idx] && (tag_mem[rd_idx] == rd_tag);

  assert_clear_R8 : assert property (@(posedge clk) disable iff (rst)
    $past(clear) |-> (valid_q == '0));

  assert_clear_blocks_fill_R9 : assert property (@(posedge clk) disable iff (rst)
    clear |-> !wr_en);

endmodule

// File: rtl/icache_data_store.sv
module icache_data_store #(
  parameter int LINES   = 8,
  parameter int BLOCK_W = 64
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic [$clog2(LINES)-1:0] wr_idx,
  input  logic [BLOCK_W-1:0]       wr_block,
  input  logic [$clog2(LINES)-1:0] rd_idx,
  output logic [BLOCK_W-1:0]       rd_block
);
  logic [BLOCK_W-1:0] line_mem [LINES];

  always_ff @(posedge clk) begin
    if (wr_en) line_mem[wr_idx] <= wr_block;
  end

  assign rd_block = line_mem[rd_idx];

endmodule

// File: rtl/icache_refill_ctrl.sv
module icache_refill_ctrl
  import icache_pkg::*;
#(
  parameter int BASE_W = 11,
  parameter int MEM_W  = 16,
  parameter int BEATS  = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start,
  input  logic                          restart,
  input  logic [BASE_W-1:0]             base,
  output logic                          mem_en,
  output logic [BASE_W+$clog2(BEATS)-1:0] mem_addr,
  input  logic [MEM_W-1:0]              mem_rdata,
  output logic                          active,
  output logic                          done,
  output logic [MEM_W*BEATS-1:0]        block
);
  localparam int BEAT_W  = $clog2(BEATS);
  localparam int BLOCK_W = MEM_W * BEATS;
  localparam logic [BEAT_W:0]   ISS_END   = (BEAT_W+1)'(BEATS);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

  fill_state_t                 state_q;
  logic [BASE_W-1:0]           base_q;
  logic [BEAT_W:0]             iss_q;
  logic                        mem_en_q;
  logic [BASE_W+BEAT_W-1:0]    mem_addr_q;
  logic                        rsp_q;
  logic [BEAT_W-1:0]           rsp_idx_q;
  logic [BLOCK_W-1:0]          stage_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= FILL_IDLE;
      base_q     <= '0;
      iss_q      <= '0;
      mem_en_q   <= 1'b0;
      mem_addr_q <= '0;
      rsp_q      <= 1'b0;
      rsp_idx_q  <= '0;
      stage_q    <= '0;
    end else if (start || restart) begin
      // Fresh sequence: beat 0 issues now, stale responses are dropped.
      state_q    <= FILL_RUN;
      if (start) base_q <= base;
      mem_en_q   <= 1'b1;
      mem_addr_q <= {(start ? base : base_q), BEAT_W'(0)};
      iss_q      <= (BEAT_W+1)'(1);
      rsp_q      <= 1'b0;
      rsp_idx_q  <= '0;
    end else if (state_q == FILL_RUN) begin
      if (mem_en_q) begin
        if (iss_q == ISS_END) begin
          mem_en_q <= 1'b0;
        end else begin
          mem_addr_q <= {base_q, iss_q[BEAT_W-1:0]};
          iss_q      <= iss_q + (BEAT_W+1)'(1);
        end
      end
      rsp_q <= mem_en_q;
      if (rsp_q) begin
        stage_q[rsp_idx_q*MEM_W +: MEM_W] <= mem_rdata;
        rsp_idx_q <= rsp_idx_q + BEAT_W'(1);
        if (rsp_idx_q == LAST_BEAT) state_q <= FILL_IDLE;
      end
    end
  end

  // The last beat goes straight from the bus into the line write.
  always_comb begin
    block = stage_q;
    block[(BEATS-1)*MEM_W +: MEM_W] = mem_rdata;
  end

  assign done     = (state_q == FILL_RUN) && rsp_q && (rsp_idx_q == LAST_BEAT) && !restart;
  assign active   = (state_q == FILL_RUN);
  assign mem_en   = mem_en_q;
  assign mem_addr = mem_addr_q;

  assert_en_in_fill_R7 : assert property (@(posedge clk) disable iff (rst)
    mem_en_q |-> (state_q == FILL_RUN));

  assert_beat_step_R5 : assert property (@(posedge clk) disable iff (rst)
    (mem_en_q && $past(mem_en_q) && !$past(start || restart)) |->
      (mem_addr_q[BEAT_W-1:0] == $past(mem_addr_q[BEAT_W-1:0]) + BEAT_W'(1)));

  assert_restart_beat0_R9 : assert property (@(posedge clk) disable iff (rst)
    $past(restart) |-> (mem_en_q && mem_addr_q[BEAT_W-1:0] == '0 && !rsp_q));

endmodule

// File: rtl/icache_l1.sv
module icache_l1 #(
  parameter int ADDR_W      = 12,
  parameter int WORD_W      = 32,
  parameter int BLOCK_WORDS = 2,
  parameter int MEM_W       = 16,
  parameter int LINES       = 8
) (
  input  logic                                     clk,
  input  logic                                     rst,
  input  logic                                     fetch_en,
  input  logic [ADDR_W-1:0]                        fetch_addr,
  output logic [WORD_W-1:0]                        fetch_data,
  output logic                                     fetch_busy,
  input  logic                                     invalidate,
  output logic                                     mem_en,
  output logic [ADDR_W-$clog2(BLOCK_WORDS)+$clog2(BLOCK_WORDS*WORD_W/MEM_W)-1:0] mem_addr,
  input  logic [MEM_W-1:0]                         mem_rdata
);
  localparam int OFF_W   = $clog2(BLOCK_WORDS);
  localparam int IDX_W   = $clog2(LINES);
  localparam int TAG_W   = ADDR_W - OFF_W - IDX_W;
  localparam int BLOCK_W = WORD_W * BLOCK_WORDS;
  localparam int BEATS   = BLOCK_W / MEM_W;
  localparam int BASE_W  = ADDR_W - OFF_W;

  logic [IDX_W-1:0]   req_idx;
  logic [TAG_W-1:0]   req_tag;
  logic [OFF_W-1:0]   req_off;
  logic [ADDR_W-1:0]  pend_q;
  logic [OFF_W-1:0]   pend_off;
  logic [IDX_W-1:0]   pend_idx;
  logic [TAG_W-1:0]   pend_tag;
  logic               busy_q;
  logic [WORD_W-1:0]  data_q;
  logic               accept, tag_hit, hit, start_fill, restart_fill;
  logic               fill_active, fill_done;
  logic [BLOCK_W-1:0] rd_block, fill_block;
  logic [WORD_W-1:0]  hit_word, fill_word;

  assign req_off  = fetch_addr[OFF_W-1:0];
  assign req_idx  = fetch_addr[OFF_W +: IDX_W];
  assign req_tag  = fetch_addr[ADDR_W-1 -: TAG_W];
  assign pend_off = pend_q[OFF_W-1:0];
  assign pend_idx = pend_q[OFF_W +: IDX_W];
  assign pend_tag = pend_q[ADDR_W-1 -: TAG_W];

  assign accept       = fetch_en && !busy_q;
  assign hit          = tag_hit && !invalidate;
  assign start_fill   = accept && !hit;
  assign restart_fill = invalidate && fill_active;

  icache_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk    (clk),
    .rst    (rst),
    .clear  (invalidate),
    .rd_idx (req_idx),
    .rd_tag (req_tag),
    .rd_hit (tag_hit),
    .wr_en  (fill_done),
    .wr_idx (pend_idx),
    .wr_tag (pend_tag)
  );

  icache_data_store #(.LINES(LINES), .BLOCK_W(BLOCK_W)) u_data (
    .clk      (clk),
    .wr_en    (fill_done),
    .wr_idx   (pend_idx),
    .wr_block (fill_block),
    .rd_idx   (req_idx),
    .rd_block (rd_block)
  );

  icache_refill_ctrl #(.BASE_W(BASE_W), .MEM_W(MEM_W), .BEATS(BEATS)) u_fill (
    .clk       (clk),
    .rst       (rst),
    .start     (start_fill),
    .restart   (restart_fill),
    .base      (fetch_addr[ADDR_W-1:OFF_W]),
    .mem_en    (mem_en),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata),
    .active    (fill_active),
    .done      (fill_done),
    .block     (fill_block)
  );

  // Word selection within a line, for both the hit and the refill path.
  always_comb begin
    hit_word  = '0;
    fill_word = '0;
    for (int w = 0; w < BLOCK_WORDS; w++) begin
      if (req_off == OFF_W'(w))  hit_word  = rd_block[w*WORD_W +: WORD_W];
      if (pend_off == OFF_W'(w)) fill_word = fill_block[w*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      data_q <= '0;
      pend_q <= '0;
    end else begin
      if (start_fill) begin
        busy_q <= 1'b1;
        pend_q <= fetch_addr;
      end else if (accept) begin
        data_q <= hit_word;
      end
      if (fill_done) begin
        busy_q <= 1'b0;
        data_q <= fill_word;
      end
    end
  end

  assign fetch_busy = busy_q;
  assign fetch_data = data_q;

  assert_busy_drop_R6 : assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> $past(fill_done));

  assert_mem_idle_R7 : assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> !mem_en);

  assert_pend_hold_R10 : assert property (@(posedge clk) disable iff (rst)
    (busy_q && $past(busy_q)) |-> $stable(pend_q));

endmodule

// File: tb/icache_l1_tb.sv
module icache_l1_tb;
  localparam int CLK_PERIOD  = 10;
  localparam int ADDR_W      = 12;
  localparam int WORD_W      = 32;
  localparam int BLOCK_WORDS = 2;
  localparam int MEM_W       = 16;
  localparam int LINES       = 8;
  localparam int OFF_W   = $clog2(BLOCK_WORDS);
  localparam int IDX_W   = $clog2(LINES);
  localparam int TAG_W   = ADDR_W - OFF_W - IDX_W;
  localparam int BLOCK_W = WORD_W * BLOCK_WORDS;
  localparam int BEATS   = BLOCK_W / MEM_W;
  localparam int BEAT_W  = $clog2(BEATS);
  localparam int MEM_AW  = ADDR_W - OFF_W + BEAT_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fetch_en = 1'b0;
  logic [ADDR_W-1:0] fetch_addr = '0;
  logic [WORD_W-1:0] fetch_data;
  logic fetch_busy;
  logic invalidate = 1'b0;
  logic mem_en;
  logic [MEM_AW-1:0] mem_addr;
  logic [MEM_W-1:0] mem_rdata = '0;

  int checks = 0;
  int errors = 0;
  bit m_valid [LINES];
  logic [TAG_W-1:0] m_tag [LINES];

  always #(CLK_PERIOD/2) clk = ~clk;

  icache_l1 #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .BLOCK_WORDS(BLOCK_WORDS),
              .MEM_W(MEM_W), .LINES(LINES)) u_dut (
    .clk(clk), .rst(rst), .fetch_en(fetch_en), .fetch_addr(fetch_addr),
    .fetch_data(fetch_data), .fetch_busy(fetch_busy), .invalidate(invalidate),
    .mem_en(mem_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
  );

  function automatic logic [MEM_W-1:0] mem_word(input logic [MEM_AW-1:0] a);
    logic [31:0] t;
    t = 32'(a) * 32'h9E3779B1 + 32'h1234567;
    return t[MEM_W-1:0] ^ t[31 -: MEM_W];
  endfunction

  // Instruction memory: one-cycle read latency.
  always @(posedge clk) if (mem_en) mem_rdata <= mem_word(mem_addr);

  function automatic logic [WORD_W-1:0] exp_word(input logic [ADDR_W-1:0] a);
    logic [BLOCK_W-1:0] blk;
    for (int b = 0; b < BEATS; b++)
      blk[b*MEM_W +: MEM_W] = mem_word({a[ADDR_W-1:OFF_W], BEAT_W'(b)});
    return blk[int'(a[OFF_W-1:0])*WORD_W +: WORD_W];
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int l = 0; l < LINES; l++) m_valid[l] = 1'b0;
  endtask

  // One fetch; inv_with pulses invalidate on the accepting edge, inv_at > 0
  // pulses it mid-refill after that many beats were seen.
  task automatic fetch(input logic [ADDR_W-1:0] a, input bit inv_with,
                       input int inv_at, input string req);
    int idx, beats, exp_b, cyc;
    bit exp_hit;
    idx = int'(a[OFF_W +: IDX_W]);
    exp_hit = !inv_with && m_valid[idx] && m_tag[idx] == a[ADDR_W-1 -: TAG_W];
    if (inv_with) model_clear();
    fetch_en = 1'b1; fetch_addr = a; invalidate = inv_with;
    @(negedge clk);
    fetch_en = 1'b0; invalidate = 1'b0;
    beats = 0; exp_b = 0; cyc = 0;
    while (fetch_busy && cyc < 60) begin
      invalidate = 1'b0;
      if (mem_en) begin
        chk(mem_addr == {a[ADDR_W-1:OFF_W], BEAT_W'(exp_b)}, "R5", "beat address",
            64'(mem_addr), 64'({a[ADDR_W-1:OFF_W], BEAT_W'(exp_b)}));
        beats++; exp_b++;
        if (inv_at > 0 && beats == inv_at) begin
          invalidate = 1'b1; exp_b = 0; model_clear();
        end
      end
      cyc++;
      fetch_en = 1'($urandom);          // R10: ignored while busy
      fetch_addr = ADDR_W'($urandom);
      @(negedge clk);
    end
    fetch_en = 1'b0; invalidate = 1'b0;
    if (exp_hit) begin
      chk(cyc == 0, "R2", "hit busy cycles", 64'(cyc), 0);
    end else begin
      chk(cyc == BEATS + 1 + inv_at, (inv_at > 0) ? "R9" : "R6", "miss busy cycles",
          64'(cyc), 64'(BEATS + 1 + inv_at));
      chk(beats == BEATS + inv_at, (inv_at > 0) ? "R9" : "R5", "beat count",
          64'(beats), 64'(BEATS + inv_at));
      m_valid[idx] = 1'b1;
      m_tag[idx] = a[ADDR_W-1 -: TAG_W];
    end
    chk(!mem_en, "R7", "mem_en after fetch", 64'(mem_en), 0);
    chk(fetch_data == exp_word(a), req, "fetch_data", 64'(fetch_data), 64'(exp_word(a)));
  endtask

  task automatic pulse_inval();
    invalidate = 1'b1;
    @(negedge clk);
    invalidate = 1'b0;
    model_clear();
    chk(!fetch_busy && !mem_en, "R8", "idle after invalidate",
        64'({fetch_busy, mem_en}), 0);
  endtask

  initial begin
    model_clear();
    void'($urandom(32'd1977));
    repeat (3) @(negedge clk);
    chk(!fetch_busy, "R1", "busy in reset", 64'(fetch_busy), 0);
    chk(!mem_en, "R1", "mem_en in reset", 64'(mem_en), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!fetch_busy && !mem_en, "R1", "idle after reset", 64'({fetch_busy, mem_en}), 0);

    fetch(12'h010, 1'b0, 0, "R1");   // first fetch misses
    fetch(12'h011, 1'b0, 0, "R11");  // other word, same line: hit
    fetch(12'h010, 1'b0, 0, "R3");
    fetch(12'h020 + 12'h010, 1'b0, 0, "R4");  // same index, other tag
    fetch(12'h010, 1'b0, 0, "R4");
    fetch(12'h013, 1'b0, 0, "R2");
    pulse_inval();
    fetch(12'h010, 1'b0, 0, "R4");   // tag matches but line invalid
    fetch(12'h013, 1'b1, 0, "R8");   // request with concurrent invalidate
    fetch(12'h013, 1'b0, 0, "R11");
    fetch(12'h045, 1'b0, 2, "R9");   // abandon after two beats
    fetch(12'h044, 1'b0, 0, "R9");   // restarted refill left line valid
    fetch(12'h013, 1'b0, 0, "R9");   // other lines were dropped
    fetch(12'h067, 1'b0, 1, "R9");
    fetch(12'h069, 1'b0, BEATS, "R9");
    fetch(12'h068, 1'b0, 0, "R10");

    for (int i = 0; i < 300; i++) begin
      if ($urandom_range(0, 24) == 0) pulse_inval();
      fetch(ADDR_W'($urandom_range(0, 127)), 1'b0, 0, "R2");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule